// File: doc/BRIEF.md
# UART Receive Queue with Trigger Level and Idle Timeout

This block holds received characters for a 16550-style serial port until the host reads them. A deserialiser hands it one byte per push strobe, or a break strobe when it sees a break condition. The host reads bytes through a read strobe, reads line status through a second strobe, and writes the FIFO control byte. In queued mode the bytes pass through a first-in first-out store that is `DEPTH` entries deep (16 by default). In single-register mode one holding register takes the place of the queue.

The block reports several things: the byte at the head, the data-ready, overrun and break status flags, the number of stored bytes, and the receive trigger level selected by the control byte. It also keeps an idle timer. The timer length is four character times, and a character time is computed from the line framing settings and the clock cycles per bit. When the timer runs out while bytes are still waiting, a character-timeout flag is raised so that the interrupt logic can wake the host. A one-cycle pulse tells the transmit side when its FIFO has to be emptied.

Top module: `uart_rxq`

## Requirements
- R1: After reset, the count, data-ready, overrun, break and timeout outputs are 0. The control byte is 0x00, the trigger level is 1, and the read data is 0.
- R2: In queued mode (control bit 0 = 1), bytes are read out in the order they were pushed. `count_o` is incremented by each accepted push and decremented by each read of a non-empty queue.
- R3: A push into a queue that holds `DEPTH` bytes leaves the stored bytes and the count unchanged and sets overrun.
- R4: Control bits 7:6 select the trigger level. The encodings 00, 01, 10 and 11 give 1, DEPTH/4, DEPTH/2 and DEPTH-2 bytes (1, 4, 8, 14 at the default depth).
- R5: A control write keeps only bits 7, 6, 3 and 0 (data AND 0xC9). Bit 1 empties the receive queue and clears data-ready, break and any timeout. Bit 2 raises `tx_flush_o` for one cycle and leaves the receive queue as it is.
- R6: A control write that changes bit 0 empties the receive queue and raises `tx_flush_o`, whatever bits 1 and 2 are.
- R7: In queued mode, each push restarts an idle timer of T = 4 × frame bits × `bit_cycles_i` clock cycles. So does each data read that leaves bytes behind. `timeout_o` rises exactly T cycles after the restart if the queue is not empty.
- R8: A data read clears `timeout_o`. A data read that empties the queue clears data-ready and break. A data read that leaves bytes behind keeps data-ready set.
- R9: A break strobe stores a zero byte and sets both the break and data-ready flags. A break strobe takes priority over a push in the same cycle.
- R10: In single-register mode, a byte that arrives while data-ready is still set raises overrun and replaces the held byte.
- R11: A line status read clears break and overrun and leaves data-ready unchanged.
- R12: Frame bits = 1 start bit + (5 + `wlen_i`) data bits + `par_en_i` parity bit + (`stop2_i` ? 2 : 1) stop bits.
- R13: A read of an empty queue in queued mode returns 0 and leaves the count at 0.
- R14: A push and a read in the same cycle on a full queue store the new byte without overrun. A control write in a cycle takes priority over a push or read in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Received-byte strobe |
| push_data_i | input | 8 | Received byte |
| brk_i | input | 1 | Break-received strobe |
| rd_i | input | 1 | Host read of the data register |
| lsr_rd_i | input | 1 | Host read of the line status |
| fcr_wr_i | input | 1 | Control byte write strobe |
| fcr_data_i | input | 8 | Control byte written |
| bit_cycles_i | input | BITCYC_W | Clock cycles per serial bit |
| wlen_i | input | 2 | Data bits minus five |
| par_en_i | input | 1 | Parity bit present |
| stop2_i | input | 1 | Two stop bits |
| rd_data_o | output | 8 | Byte presented to the host |
| data_ready_o | output | 1 | Data-ready flag |
| overrun_o | output | 1 | Overrun flag |
| break_o | output | 1 | Break flag |
| count_o | output | CNT_W | Bytes stored |
| trig_level_o | output | CNT_W | Selected trigger level in bytes |
| fcr_o | output | 8 | Retained control bits |
| tx_flush_o | output | 1 | One-cycle transmit flush pulse |
| timeout_o | output | 1 | Character timeout pending |

## Verification
The hardest case to reach is the timeout restart in the middle of a countdown. The bench pushes two bytes and waits partway through the timer. It then reads one byte, which must restart the timer from that read. The bench samples the flag one cycle before T and again at T after the read, so a timer that only restarts on pushes is caught. The full-queue case also needs careful ordering: the bench fills the queue and applies a simultaneous push and read before it pushes a lone byte. This shows that the freed slot takes the byte without overrun, and that the lone byte is then discarded.

// File: rtl/uart_rxq_pkg.sv
`timescale 1ns/1ps
package uart_rxq_pkg;
    localparam int FCR_EN    = 0;
    localparam int FCR_RXCLR = 1;
    localparam int FCR_TXCLR = 2;
    localparam logic [7:0] FCR_KEEP = 8'hC9;

    // trigger level in bytes for a given select code
    function automatic int trig_bytes(input logic [1:0] sel, input int depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - 2;
        endcase
    endfunction
endpackage

// File: rtl/uart_rxq_frame.sv
`timescale 1ns/1ps
module uart_rxq_frame #(
    parameter int BITCYC_W = 16,
    parameter int TMR_W    = BITCYC_W + 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BITCYC_W-1:0] bit_cycles_i,
    input  logic [1:0]          wlen_i,
    input  logic                par_en_i,
    input  logic                stop2_i,
    output logic [TMR_W-1:0]    tmo_cycles_o
);
    logic [3:0]       frame_bits;
    logic [TMR_W-1:0] tmo_d, tmo_q;

    // start + (5 + wlen) data + parity + 1 or 2 stop bits
    always_comb begin
        frame_bits = 4'd7 + {2'b00, wlen_i} + {3'b000, par_en_i} + {3'b000, stop2_i};
        tmo_d      = (TMR_W'(frame_bits) * TMR_W'(bit_cycles_i)) << 2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmo_q <= '0;
        else        tmo_q <= tmo_d;
    end

    assign tmo_cycles_o = tmo_q;
endmodule

// File: rtl/uart_rxq_store.sv
`timescale 1ns/1ps
module uart_rxq_store #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             wr_i,
    input  logic [W-1:0]     wdata_i,
    input  logic             rd_i,
    output logic [W-1:0]     head_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } ptr_t;

    ptr_t       d, q;
    logic       do_wr, do_rd;
    logic [W-1:0] mem [DEPTH];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        d     = q;
        do_rd = rd_i && (q.cnt != '0);
        do_wr = wr_i && ((q.cnt != CNT_W'(DEPTH)) || do_rd);
        if (clr_i) begin
            d = '0;
        end else begin
            if (do_wr) d.wp = bump(q.wp);
            if (do_rd) d.rp = bump(q.rp);
            if (do_wr && !do_rd)      d.cnt = q.cnt + CNT_W'(1);
            else if (do_rd && !do_wr) d.cnt = q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (do_wr && !clr_i) mem[q.wp] <= wdata_i;
    end

    assign head_o  = mem[q.rp];
    assign count_o = q.cnt;
    assign full_o  = (q.cnt == CNT_W'(DEPTH));
endmodule

// File: rtl/uart_rxq.sv
`timescale 1ns/1ps
module uart_rxq
    import uart_rxq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int BITCYC_W = 16,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int TMR_W   = BITCYC_W + 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push_i,
    input  logic [7:0]          push_data_i,
    input  logic                brk_i,
    input  logic                rd_i,
    input  logic                lsr_rd_i,
    input  logic                fcr_wr_i,
    input  logic [7:0]          fcr_data_i,
    input  logic [BITCYC_W-1:0] bit_cycles_i,
    input  logic [1:0]          wlen_i,
    input  logic                par_en_i,
    input  logic                stop2_i,
    output logic [7:0]          rd_data_o,
    output logic                data_ready_o,
    output logic                overrun_o,
    output logic                break_o,
    output logic [CNT_W-1:0]    count_o,
    output logic [CNT_W-1:0]    trig_level_o,
    output logic [7:0]          fcr_o,
    output logic                tx_flush_o,
    output logic                timeout_o
);
    typedef struct packed {
        logic [7:0]       fcr;
        logic [7:0]       hold;
        logic             dr;
        logic             oe;
        logic             bi;
        logic             tmo;
        logic             txfl;
        logic [TMR_W-1:0] tmr;
    } st_t;

    st_t              d, q;
    logic [TMR_W-1:0] tmo_cycles;
    logic             st_clr, st_wr, st_rd;
    logic [7:0]       st_wdata, fifo_head;
    logic [CNT_W-1:0] fifo_cnt;
    logic             fifo_full;
    logic             fifo_on, en_flip, pop, restart;

    uart_rxq_frame #(.BITCYC_W(BITCYC_W), .TMR_W(TMR_W)) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_cycles_i(bit_cycles_i),
        .wlen_i      (wlen_i),
        .par_en_i    (par_en_i),
        .stop2_i     (stop2_i),
        .tmo_cycles_o(tmo_cycles)
    );

    uart_rxq_store #(.DEPTH(DEPTH), .W(8)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (st_clr),
        .wr_i   (st_wr),
        .wdata_i(st_wdata),
        .rd_i   (st_rd),
        .head_o (fifo_head),
        .count_o(fifo_cnt),
        .full_o (fifo_full)
    );

    assign fifo_on = q.fcr[FCR_EN];
    assign en_flip = fcr_data_i[FCR_EN] ^ q.fcr[FCR_EN];

    always_comb begin
        d        = q;
        d.txfl   = 1'b0;
        st_clr   = 1'b0;
        st_wr    = 1'b0;
        st_rd    = 1'b0;
        st_wdata = push_data_i;
        pop      = 1'b0;
        restart  = 1'b0;

        if (fcr_wr_i) begin
            // control write owns the cycle
            d.fcr  = fcr_data_i & FCR_KEEP;
            d.txfl = fcr_data_i[FCR_TXCLR] | en_flip;
            if (fcr_data_i[FCR_RXCLR] | en_flip) begin
                st_clr = 1'b1;
                d.dr   = 1'b0;
                d.bi   = 1'b0;
                d.tmo  = 1'b0;
                d.tmr  = '0;
            end
        end else begin
            if (lsr_rd_i) begin
                d.bi = 1'b0;
                d.oe = 1'b0;
            end

            if (rd_i) begin
                if (fifo_on) begin
                    pop   = (fifo_cnt != '0);
                    st_rd = 1'b1;
                    d.tmo = 1'b0;
                    if (fifo_cnt <= CNT_W'(1)) begin
                        d.dr = 1'b0;
                        d.bi = 1'b0;
                    end else begin
                        restart = 1'b1;
                    end
                end else begin
                    d.dr = 1'b0;
                    d.bi = 1'b0;
                end
            end

            if (brk_i) begin
                if (fifo_on) begin
                    st_wr    = 1'b1;
                    st_wdata = 8'h00;
                    if (fifo_full && !pop) d.oe = 1'b1;
                end else begin
                    d.hold = 8'h00;
                end
                d.dr = 1'b1;
                d.bi = 1'b1;
            end else if (push_i) begin
                if (fifo_on) begin
                    st_wr   = 1'b1;
                    restart = 1'b1;
                    if (fifo_full && !pop) d.oe = 1'b1;
                end else begin
                    if (q.dr && !rd_i) d.oe = 1'b1;
                    d.hold = push_data_i;
                end
                d.dr = 1'b1;
            end

            if (restart) begin
                d.tmr = tmo_cycles;
            end else if (q.tmr != '0) begin
                d.tmr = q.tmr - TMR_W'(1);
                if (q.tmr == TMR_W'(1) && fifo_cnt != '0 && !rd_i) d.tmo = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_data_o    = fifo_on ? ((fifo_cnt != '0) ? fifo_head : 8'h00) : q.hold;
    assign data_ready_o = q.dr;
    assign overrun_o    = q.oe;
    assign break_o      = q.bi;
    assign count_o      = fifo_cnt;
    assign trig_level_o = CNT_W'(trig_bytes(q.fcr[7:6], DEPTH));
    assign fcr_o        = q.fcr;
    assign tx_flush_o   = q.txfl;
    assign timeout_o    = q.tmo;
endmodule

// File: rtl/uart_rxq_chk.sv
`timescale 1ns/1ps
module uart_rxq_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_i,
    input logic [7:0]       push_data_i,
    input logic             brk_i,
    input logic             rd_i,
    input logic             lsr_rd_i,
    input logic             fcr_wr_i,
    input logic [7:0]       fcr_data_i,
    input logic [7:0]       rd_data_o,
    input logic             data_ready_o,
    input logic             overrun_o,
    input logic             break_o,
    input logic [CNT_W-1:0] count_o,
    input logic [7:0]       fcr_o,
    input logic             tx_flush_o,
    input logic             timeout_o
);
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CNT_W'(DEPTH));

    a_r3_full_push: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_o[0] && push_i && !brk_i && !rd_i && !fcr_wr_i && count_o == CNT_W'(DEPTH)
        |=> overrun_o && count_o == CNT_W'(DEPTH));

    a_r5_rx_flush: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr_i && fcr_data_i[1] |=> count_o == '0 && !timeout_o && !data_ready_o);

    a_r6_enable_flip: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr_i && (fcr_data_i[0] != fcr_o[0]) |=> tx_flush_o && count_o == '0);

    a_r7_timeout_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> count_o != '0);

    a_r8_read_clears_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i && !fcr_wr_i |=> !timeout_o);

    a_r9_break_flags: assert property (@(posedge clk) disable iff (!rst_n)
        brk_i && !fcr_wr_i |=> break_o && data_ready_o);

    a_r10_single_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        !fcr_o[0] && push_i && !brk_i && !rd_i && !fcr_wr_i && data_ready_o
        |=> overrun_o && rd_data_o == $past(push_data_i));

    a_r11_status_read: assert property (@(posedge clk) disable iff (!rst_n)
        lsr_rd_i && !brk_i && !push_i && !fcr_wr_i |=> !break_o && !overrun_o);

    a_r13_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_o[0] && rd_i && count_o == '0 && !push_i && !brk_i && !fcr_wr_i
        |-> rd_data_o == 8'h00 ##1 count_o == '0);
endmodule

bind uart_rxq uart_rxq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push_i),
    .push_data_i (push_data_i),
    .brk_i       (brk_i),
    .rd_i        (rd_i),
    .lsr_rd_i    (lsr_rd_i),
    .fcr_wr_i    (fcr_wr_i),
    .fcr_data_i  (fcr_data_i),
    .rd_data_o   (rd_data_o),
    .data_ready_o(data_ready_o),
    .overrun_o   (overrun_o),
    .break_o     (break_o),
    .count_o     (count_o),
    .fcr_o       (fcr_o),
    .tx_flush_o  (tx_flush_o),
    .timeout_o   (timeout_o)
);

// File: tb/uart_rxq_tb.sv
`timescale 1ns/1ps
module uart_rxq_tb;
    localparam int DEPTH = 16;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_i = 0, brk_i = 0, rd_i = 0, lsr_rd_i = 0, fcr_wr_i = 0;
    logic [7:0] push_data_i = '0, fcr_data_i = '0;
    logic [15:0] bit_cycles_i = 16'd2;
    logic [1:0]  wlen_i = 2'd3;
    logic par_en_i = 0, stop2_i = 0;
    logic [7:0] rd_data_o, fcr_o;
    logic data_ready_o, overrun_o, break_o, tx_flush_o, timeout_o;
    logic [CNT_W-1:0] count_o, trig_level_o;

    int n_chk = 0;
    int n_bad = 0;
    bit mon_on = 0;
    logic [7:0] exp_q[$];

    always #5 clk = ~clk;

    uart_rxq #(.DEPTH(DEPTH), .BITCYC_W(16)) u_dut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
        .brk_i(brk_i), .rd_i(rd_i), .lsr_rd_i(lsr_rd_i), .fcr_wr_i(fcr_wr_i),
        .fcr_data_i(fcr_data_i), .bit_cycles_i(bit_cycles_i), .wlen_i(wlen_i),
        .par_en_i(par_en_i), .stop2_i(stop2_i), .rd_data_o(rd_data_o),
        .data_ready_o(data_ready_o), .overrun_o(overrun_o), .break_o(break_o),
        .count_o(count_o), .trig_level_o(trig_level_o), .fcr_o(fcr_o),
        .tx_flush_o(tx_flush_o), .timeout_o(timeout_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push_byte(input logic [7:0] b, input bit kept);
        push_i = 1; push_data_i = b;
        if (kept) exp_q.push_back(b);
        tick();
        push_i = 0;
    endtask

    task automatic rd_byte();
        rd_i = 1; tick(); rd_i = 0;
    endtask

    task automatic lsr_read();
        lsr_rd_i = 1; tick(); lsr_rd_i = 0;
    endtask

    task automatic fcr_write(input logic [7:0] v);
        fcr_wr_i = 1; fcr_data_i = v; tick(); fcr_wr_i = 0;
    endtask

    task automatic send_break();
        brk_i = 1; exp_q.push_back(8'h00); tick(); brk_i = 0;
    endtask

    // monitor: compare every queued-mode read against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rd_i && mon_on) begin
            logic [7:0] e;
            e = (exp_q.size() == 0) ? 8'h00 : exp_q.pop_front();
            chk("R2/R13 read data", {24'd0, rd_data_o}, {24'd0, e});
        end
    end

    initial begin
        #1_000_000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        // R1 reset state
        chk("R1 count", 32'(count_o), 0);
        chk("R1 flags", {29'd0, data_ready_o, overrun_o, break_o}, 0);
        chk("R1 timeout", 32'(timeout_o), 0);
        chk("R1 fcr", 32'(fcr_o), 0);
        chk("R1 trig", 32'(trig_level_o), 1);
        chk("R1 rd_data", 32'(rd_data_o), 0);

        // R10 single-register mode
        push_byte(8'h5A, 0);
        chk("R10 hold", 32'(rd_data_o), 32'h5A);
        chk("R10 dr", 32'(data_ready_o), 1);
        chk("R10 no oe", 32'(overrun_o), 0);
        push_byte(8'h3C, 0);
        chk("R10 overrun", 32'(overrun_o), 1);
        chk("R10 replaced", 32'(rd_data_o), 32'h3C);
        lsr_read();
        chk("R11 oe clear", 32'(overrun_o), 0);
        chk("R11 dr kept", 32'(data_ready_o), 1);
        rd_byte();
        chk("R10 read clears dr", 32'(data_ready_o), 0);

        // R4 / R5 / R6 control writes
        fcr_write(8'hC1);
        chk("R6 fcr", 32'(fcr_o), 32'hC1);
        chk("R4 trig 14", 32'(trig_level_o), 14);
        chk("R6 tx flush on enable flip", 32'(tx_flush_o), 1);
        tick();
        chk("R5 tx flush one cycle", 32'(tx_flush_o), 0);
        fcr_write(8'h47);
        chk("R5 keep mask", 32'(fcr_o), 32'h41);
        chk("R4 trig 4", 32'(trig_level_o), 4);
        chk("R5 tx flush bit2", 32'(tx_flush_o), 1);
        fcr_write(8'h81);
        chk("R4 trig 8", 32'(trig_level_o), 8);
        chk("R5 no tx flush", 32'(tx_flush_o), 0);
        fcr_write(8'hCF);
        chk("R5 keep mask C9", 32'(fcr_o), 32'hC9);
        fcr_write(8'h01);
        chk("R4 trig 1", 32'(trig_level_o), 1);

        // R2 ordering, R8 partial read, R13 empty read
        mon_on = 1;
        for (int i = 0; i < 5; i++) push_byte(8'h10 + 8'(i), 1);
        chk("R2 count 5", 32'(count_o), 5);
        rd_byte(); rd_byte();
        chk("R2 count 3", 32'(count_o), 3);
        chk("R8 dr kept", 32'(data_ready_o), 1);
        rd_byte(); rd_byte(); rd_byte();
        chk("R8 dr cleared", 32'(data_ready_o), 0);
        chk("R13 rd_data empty", 32'(rd_data_o), 0);
        rd_byte();
        chk("R13 count stays 0", 32'(count_o), 0);

        // R3 / R14 full queue
        for (int i = 0; i < DEPTH; i++) push_byte(8'hA0 + 8'(i), 1);
        chk("R3 count full", 32'(count_o), DEPTH);
        push_i = 1; push_data_i = 8'hB7; rd_i = 1; exp_q.push_back(8'hB7);
        tick();
        push_i = 0; rd_i = 0;
        chk("R14 no overrun", 32'(overrun_o), 0);
        chk("R14 count full", 32'(count_o), DEPTH);
        push_byte(8'hEE, 0);
        chk("R3 overrun", 32'(overrun_o), 1);
        chk("R3 count kept", 32'(count_o), DEPTH);
        for (int i = 0; i < DEPTH; i++) rd_byte();
        chk("R3 drained", 32'(count_o), 0);
        lsr_read();

        // R7 timeout: 10 frame bits * 2 cycles * 4 = 80
        push_byte(8'h61, 1);
        repeat (79) tick();
        chk("R7 not yet", 32'(timeout_o), 0);
        tick();
        chk("R7 expiry", 32'(timeout_o), 1);
        rd_byte();
        chk("R8 read clears timeout", 32'(timeout_o), 0);
        chk("R8 dr cleared on empty", 32'(data_ready_o), 0);

        // R7 restart by a read that leaves data
        push_byte(8'h62, 1); push_byte(8'h63, 1);
        repeat (40) tick();
        rd_byte();
        repeat (79) tick();
        chk("R7 restart not yet", 32'(timeout_o), 0);
        tick();
        chk("R7 restart expiry", 32'(timeout_o), 1);
        rd_byte();

        // R12 frame 1+5+1+2 = 9 bits -> 72 cycles
        wlen_i = 2'd0; par_en_i = 1; stop2_i = 1;
        tick();
        push_byte(8'h64, 1);
        repeat (71) tick();
        chk("R12 not yet", 32'(timeout_o), 0);
        tick();
        chk("R12 expiry", 32'(timeout_o), 1);
        push_byte(8'h65, 1);
        fcr_write(8'h05);
        chk("R5 bit2 keeps rx", 32'(count_o), 2);
        chk("R5 bit2 pulse", 32'(tx_flush_o), 1);
        repeat (80) tick();
        chk("R7 timeout before flush", 32'(timeout_o), 1);
        fcr_write(8'h03);
        exp_q.delete();
        chk("R5 flush count", 32'(count_o), 0);
        chk("R5 flush timeout", 32'(timeout_o), 0);
        chk("R5 flush dr", 32'(data_ready_o), 0);

        // R9 break
        send_break();
        chk("R9 break flag", 32'(break_o), 1);
        chk("R9 dr", 32'(data_ready_o), 1);
        chk("R9 zero byte", 32'(rd_data_o), 0);
        chk("R9 count", 32'(count_o), 1);
        lsr_read();
        chk("R11 break clear", 32'(break_o), 0);
        chk("R11 dr kept", 32'(data_ready_o), 1);
        send_break();
        rd_byte();
        chk("R8 break kept with data", 32'(break_o), 1);
        rd_byte();
        chk("R8 empty clears break", 32'(break_o), 0);
        chk("R8 empty clears dr", 32'(data_ready_o), 0);

        // R6 disable flushes queue
        for (int i = 0; i < 3; i++) push_byte(8'h70 + 8'(i), 1);
        fcr_write(8'h00);
        exp_q.delete();
        mon_on = 0;
        chk("R6 count", 32'(count_o), 0);
        chk("R6 dr", 32'(data_ready_o), 0);
        chk("R6 tx flush", 32'(tx_flush_o), 1);
        push_byte(8'h77, 0);
        chk("R10 hold after disable", 32'(rd_data_o), 32'h77);
        chk("R10 count unused", 32'(count_o), 0);

        tick();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule